// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside a program sequencer and runs counted loops without branch instructions. One setup command gives it an iteration count and the first and last addresses of the loop body. Each cycle it compares the fetch address with the last address of the active loop. If more iterations remain, it overrides the next fetch address with the first body address in the same cycle. On the last iteration it lets fetch fall through and returns to the enclosing loop.

Loops nest. A setup issued inside a running loop saves the running loop's state on a small internal stack, and that state comes back when the inner loop is done. A separate repeat command holds fetch on the instruction that follows it for a given number of cycles and needs no addresses. A stall input freezes all loop bookkeeping. A sticky error flag reports a setup that found every nesting level in use.

The sequencer uses `next_pc_o` as its next fetch address whenever it advances. `redirect_o` marks the cycles in which that address differs from the sequential one.

Top module: `hw_loop_ctrl`

## Requirements
- R1: After reset no loop or repeat is in progress, `overflow_o` is 0, `redirect_o` is 0 and `next_pc_o` equals `pc_i + 1`.
- R2: A setup command with a nonzero count loads the count, body start and body end in one cycle. Whenever `pc_i` equals the active body end and the remaining count is above one, `next_pc_o` is the body start in that same cycle and the count drops by one.
- R3: When `pc_i` equals the active body end on the final iteration, `next_pc_o` is `pc_i + 1` and the loop ends. A loop with count N therefore runs its body exactly N times.
- R4: A setup command with a count of zero starts no loop and sets `next_pc_o` to body end + 1 in the cycle of the command, with `redirect_o` high.
- R5: A setup issued while loops are running saves the running loop. When the new loop ends, the saved loop resumes with its remaining count, start and end intact. Up to 4 loops (parameter DEPTH) can be active at once.
- R6: A setup command issued while DEPTH loops are active leaves all loop state unchanged and sets `overflow_o`. `overflow_o` then stays high until reset.
- R7: A repeat command with count N makes the following instruction execute N times: `next_pc_o` equals `pc_i` for the first N-1 cycles at that instruction. A repeat count of 0 or 1 holds nothing.
- R8: When the repeated instruction is the body end of an active loop, the end-of-body check applies only on its final repetition.
- R9: While `stall_i` is high, `redirect_o` is 0, commands are ignored, and no count or nesting state changes.
- R10: `loop_active_o` is high exactly while at least one loop or a repeat hold is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | AW | Address of the instruction being fetched this cycle |
| stall_i | input | 1 | Sequencer stalled; freezes all loop bookkeeping |
| setup_i | input | 1 | Loop setup command at the current instruction |
| setup_count_i | input | CW | Iteration count for the setup command |
| setup_start_i | input | AW | First body address for the setup command |
| setup_end_i | input | AW | Last body address for the setup command |
| rep_i | input | 1 | Repeat command at the current instruction |
| rep_count_i | input | CW | Number of executions of the following instruction |
| next_pc_o | output | AW | Next fetch address |
| redirect_o | output | 1 | High when `next_pc_o` is not the sequential address |
| loop_active_o | output | 1 | A loop or repeat is in progress |
| overflow_o | output | 1 | Sticky nesting overflow error |

## Verification
The hardest state to reach is a fully occupied nesting stack that must then unwind correctly. It takes four nested setups followed by a fifth that is rejected, and the outermost loop must later resume its second iteration from state saved several levels down. The bench runs a small program decoded from the fetch address. A loop-back in it re-executes the nested setups, so the rejection, the sticky flag and every restore are seen twice. A repeat placed on a loop's last instruction covers the interaction between the two counters.

// File: rtl/hw_loop_ctrl.sv
module hw_loop_ctrl #(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc_i,
  input  logic          stall_i,
  input  logic          setup_i,
  input  logic [CW-1:0] setup_count_i,
  input  logic [AW-1:0] setup_start_i,
  input  logic [AW-1:0] setup_end_i,
  input  logic          rep_i,
  input  logic [CW-1:0] rep_count_i,
  output logic [AW-1:0] next_pc_o,
  output logic          redirect_o,
  output logic          loop_active_o,
  output logic          overflow_o
);

  localparam int LW = $clog2(DEPTH + 1);
  localparam int SD = DEPTH - 1;
  localparam int EW = CW + 2 * AW;

  logic [CW-1:0] cnt_q, rcnt_q;
  logic [AW-1:0] start_q, end_q;
  logic [LW-1:0] lvl_q;
  logic          ovf_q;
  logic [EW-1:0] stk_q [SD];
  logic [EW-1:0] restore;

  wire go         = !stall_i;
  wire full       = (lvl_q == LW'(DEPTH));
  wire do_setup   = go && setup_i;
  wire do_rep     = go && !setup_i && rep_i;
  wire no_cmd     = go && !setup_i && !rep_i;
  wire take_setup = do_setup && !full && (setup_count_i != '0);
  wire skip       = do_setup && !full && (setup_count_i == '0);
  wire rep_hold   = no_cmd && (rcnt_q > CW'(1));
  wire at_end     = no_cmd && !rep_hold && (lvl_q != '0) && (pc_i == end_q);
  wire loop_back  = at_end && (cnt_q > CW'(1));
  wire pop        = at_end && !loop_back;

  assign next_pc_o = skip      ? setup_end_i + AW'(1) :
                     rep_hold  ? pc_i :
                     loop_back ? start_q : pc_i + AW'(1);
  assign redirect_o    = skip || rep_hold || loop_back;
  assign loop_active_o = (lvl_q != '0) || (rcnt_q > CW'(1));
  assign overflow_o    = ovf_q;

  always_comb begin
    restore = '0;
    for (int k = 0; k < SD; k++)
      if (lvl_q == LW'(k + 2)) restore = stk_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      start_q <= '0;
      end_q   <= '0;
      lvl_q   <= '0;
      rcnt_q  <= '0;
      ovf_q   <= 1'b0;
      for (int k = 0; k < SD; k++) stk_q[k] <= '0;
    end else begin
      if (do_setup && full) ovf_q <= 1'b1;
      if (take_setup) begin
        for (int k = 0; k < SD; k++)
          if (lvl_q == LW'(k + 1)) stk_q[k] <= {cnt_q, start_q, end_q};
        cnt_q   <= setup_count_i;
        start_q <= setup_start_i;
        end_q   <= setup_end_i;
        lvl_q   <= lvl_q + LW'(1);
      end else if (loop_back) begin
        cnt_q <= cnt_q - CW'(1);
      end else if (pop) begin
        if (lvl_q > LW'(1)) {cnt_q, start_q, end_q} <= restore;
        lvl_q <= lvl_q - LW'(1);
      end
      if (do_rep) rcnt_q <= rep_count_i;
      else if (no_cmd && rcnt_q != '0) rcnt_q <= rcnt_q - CW'(1);
    end
  end

endmodule

// File: rtl/hw_loop_ctrl_chk.sv
module hw_loop_ctrl_chk #(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [AW-1:0]                pc_i,
  input logic                         stall_i,
  input logic                         setup_i,
  input logic [CW-1:0]                setup_count_i,
  input logic [AW-1:0]                setup_end_i,
  input logic [AW-1:0]                next_pc_o,
  input logic                         redirect_o,
  input logic                         loop_active_o,
  input logic                         overflow_o,
  input logic [$clog2(DEPTH+1)-1:0]   lvl
);
  localparam int LW = $clog2(DEPTH + 1);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  // R6
  ovf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && setup_i && lvl == LW'(DEPTH)) |=> (overflow_o && $stable(lvl)));

  // R9
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> !redirect_o);

  // R9
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> (loop_active_o == $past(loop_active_o)) && (lvl == $past(lvl)));

  // R4
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && setup_i && setup_count_i == '0 && lvl != LW'(DEPTH))
      |-> (redirect_o && next_pc_o == setup_end_i + AW'(1)));

  // R10
  idle_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_active_o && !setup_i) |-> (!redirect_o && next_pc_o == pc_i + AW'(1)));

  // R5
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LW'(DEPTH));
endmodule

bind hw_loop_ctrl hw_loop_ctrl_chk #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .stall_i(stall_i), .setup_i(setup_i),
  .setup_count_i(setup_count_i), .setup_end_i(setup_end_i),
  .next_pc_o(next_pc_o), .redirect_o(redirect_o),
  .loop_active_o(loop_active_o), .overflow_o(overflow_o), .lvl(lvl_q)
);

// File: tb/test_hw_loop_ctrl.sv
module test_hw_loop_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        stall = 0;
  logic [15:0] pc, rst_pc = 0;
  logic        setup, rep;
  logic [15:0] s_cnt, s_start, s_end, r_cnt;
  logic [15:0] next_pc;
  logic        redirect, active, ovf;
  int          checks = 0, errors = 0;
  logic [15:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_loop_ctrl i_hw_loop_ctrl (
    .clk(clk), .rst_n(rst_n), .pc_i(pc), .stall_i(stall),
    .setup_i(setup), .setup_count_i(s_cnt), .setup_start_i(s_start),
    .setup_end_i(s_end), .rep_i(rep), .rep_count_i(r_cnt),
    .next_pc_o(next_pc), .redirect_o(redirect),
    .loop_active_o(active), .overflow_o(ovf)
  );

  always @(posedge clk)
    if (!rst_n) pc <= rst_pc;
    else if (!stall) pc <= next_pc;

  // program decoded from the fetch address
  always_comb begin
    setup = 0; rep = 0; s_cnt = 0; s_start = 0; s_end = 0; r_cnt = 0;
    case (pc)
      16'd10: begin setup = 1; s_cnt = 3; s_start = 11; s_end = 13; end
      16'd20: begin setup = 1; s_cnt = 2; s_start = 21; s_end = 25; end
      16'd21: begin setup = 1; s_cnt = 2; s_start = 22; s_end = 23; end
      16'd30: begin rep = 1; r_cnt = 4; end
      16'd35: begin rep = 1; r_cnt = 0; end
      16'd40: begin setup = 1; s_cnt = 2; s_start = 41; s_end = 43; end
      16'd42: begin rep = 1; r_cnt = 3; end
      16'd50: begin setup = 1; s_cnt = 2; s_start = 51; s_end = 60; end
      16'd51: begin setup = 1; s_cnt = 1; s_start = 52; s_end = 59; end
      16'd52: begin setup = 1; s_cnt = 1; s_start = 53; s_end = 58; end
      16'd53: begin setup = 1; s_cnt = 1; s_start = 54; s_end = 57; end
      16'd54: begin setup = 1; s_cnt = 1; s_start = 55; s_end = 56; end
      16'd70: begin setup = 1; s_cnt = 2; s_start = 71; s_end = 72; end
      16'd80: begin setup = 1; s_cnt = 1; s_start = 81; s_end = 83; end
      16'd90: begin setup = 1; s_cnt = 0; s_start = 91; s_end = 93; end
      default: ;
    endcase
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset(input logic [15:0] start);
    rst_pc = start;
    stall  = 0;
    rst_n  = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_trace(input logic [15:0] start, input int act_idx, input bit act_end, input string req);
    do_reset(start);
    for (int i = 0; i < exp_q.size(); i++) begin
      @(negedge clk);
      chk(pc == exp_q[i], req, pc, exp_q[i]);
      if (i == act_idx) chk(active == 1'b1, {req, " R10 active"}, active, 1);
    end
    chk(active == act_end, {req, " R10 active at end"}, active, act_end);
  endtask

  task automatic t_reset;
    do_reset(16'd100);
    chk(active == 0, "R1 active", active, 0);
    chk(ovf == 0, "R1 overflow", ovf, 0);
    chk(redirect == 0, "R1 redirect", redirect, 0);
    chk(next_pc == 16'd101, "R1 next_pc", next_pc, 101);
  endtask

  task automatic t_simple;
    exp_q = '{11, 12, 13, 11, 12, 13, 11, 12, 13, 14, 15};
    run_trace(16'd10, 3, 0, "R2 R3 three-pass loop");
  endtask

  task automatic t_single;
    exp_q = '{81, 82, 83, 84, 85};
    run_trace(16'd80, 1, 0, "R3 single-pass loop");
  endtask

  task automatic t_zero;
    exp_q = '{94, 95};
    run_trace(16'd90, -1, 0, "R4 zero-count skip");
  endtask

  task automatic t_nested;
    exp_q = '{21, 22, 23, 22, 23, 24, 25, 21, 22, 23, 22, 23, 24, 25, 26};
    run_trace(16'd20, 4, 0, "R5 two-level nest");
  endtask

  task automatic t_overflow;
    exp_q = '{51, 52, 53, 54, 55, 56, 57, 58, 59, 60,
              51, 52, 53, 54, 55, 56, 57, 58, 59, 60, 61, 62};
    run_trace(16'd50, 5, 0, "R5 R6 full stack");
    chk(ovf == 1, "R6 overflow sticky", ovf, 1);
    repeat (3) @(negedge clk);
    chk(ovf == 1, "R6 overflow held", ovf, 1);
  endtask

  task automatic t_repeat;
    exp_q = '{31, 31, 31, 31, 32, 33};
    run_trace(16'd30, 1, 0, "R7 repeat four");
    exp_q = '{36, 37};
    run_trace(16'd35, -1, 0, "R7 repeat zero");
  endtask

  task automatic t_rep_end;
    exp_q = '{41, 42, 43, 43, 43, 41, 42, 43, 43, 43, 44, 45};
    run_trace(16'd40, 3, 0, "R8 repeat on body end");
  endtask

  task automatic t_stall;
    do_reset(16'd70);
    @(negedge clk);
    @(negedge clk);
    chk(pc == 72, "R9 reach end", pc, 72);
    stall = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(pc == 72, "R9 pc frozen", pc, 72);
      chk(redirect == 0, "R9 no redirect", redirect, 0);
      chk(active == 1, "R9 R10 active held", active, 1);
    end
    stall = 0;
    @(negedge clk);
    chk(pc == 71, "R9 loop back after stall", pc, 71);
    @(negedge clk);
    chk(pc == 72, "R9 second pass", pc, 72);
    @(negedge clk);
    chk(pc == 73, "R9 exit after stall", pc, 73);
    chk(active == 0, "R9 R10 done", active, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_simple();
    t_single();
    t_zero();
    t_nested();
    t_overflow();
    t_repeat();
    t_rep_end();
    t_stall();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule